// File: doc/BRIEF.md
# Paged Indirect Register Window Bridge

This block lets a host reach a wide internal register space through a narrow configuration address space. The host first stores a page number (the internal address bits above bit 8) in a page register. It then reads or writes anywhere inside a 512-byte data window. The bridge joins the stored page to the low nine bits of the window address to form the internal address. It forwards the access over a valid/ready request port and holds the host bus until that port completes.

Next to the page register the bridge holds an interrupt status register and a reset trigger for the attached unit. The status register carries a firmware-hang flag, raised by an event input, and an interrupt enable bit. The hang flag is cleared by writing back the value just read. A write to the reset trigger with bit 0 set sends a single-cycle reset pulse to the unit. Every other configuration address reads zero and ignores writes.

Top module: `paged_window_bridge`

## Requirements
- R1: After reset the page register reads 0, the status register reads 0, and `irq`, `unit_rst` and `int_valid` are low.
- R2: A write to offset 0x41C stores the low PAGE_W = INT_AW-9 bits of the write data as the page. A read of 0x41C returns the page zero-extended. Higher write-data bits are ignored.
- R3: A host access to offsets 0x800 to 0x9FF issues exactly one internal request. Its `int_addr` is {page, host_addr[8:0]}, `int_we` equals the host write flag, and `int_wdata` equals the host write data.
- R4: While a request waits for `int_ready`, `int_valid` stays high, `int_addr`, `int_we` and `int_wdata` stay stable, and `host_ready` stays low.
- R5: A window access raises `host_ready` exactly one cycle after the internal handshake. For a read, `host_rdata` then holds the `int_rdata` captured at that handshake. The total latency is 2 + (wait cycles) clock cycles from presentation.
- R6: Status bit 1 (hang flag) is set by a `fw_hang_evt` pulse. Writing 1 to bit 1 at 0x428 clears it, and writing 0 to bit 1 leaves it unchanged. If an event and a clearing write arrive in the same cycle, the flag stays set.
- R7: Status bit 3 (enable) is written and read directly at 0x428. `irq` is high exactly when both bit 3 and bit 1 are set.
- R8: A write to 0x42C with bit 0 set produces a one-cycle `unit_rst` pulse in the cycle after the write. A write there with bit 0 clear produces no pulse. Offset 0x42C reads 0.
- R9: A configuration access outside the window and outside 0x41C, 0x428 and 0x42C reads 0. A write there changes no register and issues no internal request.
- R10: An access that does not target the window completes with `host_ready` high in the same cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host access request, held until host_ready |
| host_wr | input | 1 | Host access is a write |
| host_addr | input | HOST_AW | Host configuration byte offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, valid with host_ready |
| host_ready | output | 1 | Host access completes this cycle |
| int_valid | output | 1 | Internal request valid |
| int_we | output | 1 | Internal request is a write |
| int_addr | output | INT_AW | Internal address {page, offset} |
| int_wdata | output | DATA_W | Internal write data |
| int_ready | input | 1 | Internal port accepts/completes the request |
| int_rdata | input | DATA_W | Internal read data, valid with int_ready |
| fw_hang_evt | input | 1 | Firmware-hang event pulse |
| irq | output | 1 | Interrupt: hang flag and enable both set |
| unit_rst | output | 1 | One-cycle reset pulse for the attached unit |

## Verification
The hardest case to reach from the ports is a hang event that arrives in the same cycle as a clearing write-back. The stimulus places the event pulse on the exact cycle that the host write is sampled, and then reads the flag back. Long internal stalls are the second hard case. A bench responder withholds `int_ready` for a per-access delay that varies with the page. This lets the stability of the held request and the exact completion latency be checked on every page of a reduced address width.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int WIN_BITS = 9;

  localparam int PAGE_OFS = 'h41C;
  localparam int STAT_OFS = 'h428;
  localparam int URST_OFS = 'h42C;
  localparam int WIN_OFS  = 'h800;

  localparam int STAT_EN_BIT   = 3;
  localparam int STAT_HANG_BIT = 1;
  localparam int URST_BIT      = 0;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_REQ  = 2'd1,
    WIN_DONE = 2'd2
  } win_state_e;
endpackage

// File: rtl/pwb_rst_sync.sv
module pwb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/pwb_cfg_regs.sv
module pwb_cfg_regs
  import pwb_pkg::*;
#(
  parameter int HOST_AW = 12,
  parameter int DATA_W  = 32,
  parameter int PAGE_W  = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [HOST_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               hang_evt,
  output logic [PAGE_W-1:0]  page,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq,
  output logic               unit_rst
);
  localparam logic [HOST_AW-1:0] PAGE_A = HOST_AW'(PAGE_OFS);
  localparam logic [HOST_AW-1:0] STAT_A = HOST_AW'(STAT_OFS);
  localparam logic [HOST_AW-1:0] URST_A = HOST_AW'(URST_OFS);

  logic              hit_page, hit_stat, hit_urst;
  logic              page_we;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              hang_q, hang_d;
  logic              en_we;
  logic              en_q, en_d;
  logic              urst_q, urst_d;
  logic              unused_wd;

  assign hit_page  = (addr == PAGE_A);
  assign hit_stat  = (addr == STAT_A);
  assign hit_urst  = (addr == URST_A);
  assign unused_wd = ^wdata;

  // next-state logic
  always_comb begin
    page_we = wr_en & hit_page;
    page_d  = wdata[PAGE_W-1:0];
    en_we   = wr_en & hit_stat;
    en_d    = wdata[STAT_EN_BIT];
    hang_d  = hang_evt | (hang_q & ~(wr_en & hit_stat & wdata[STAT_HANG_BIT]));
    urst_d  = wr_en & hit_urst & wdata[URST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (page_we) begin
      page_q <= page_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hang_q <= 1'b0;
      urst_q <= 1'b0;
    end else begin
      hang_q <= hang_d;
      urst_q <= urst_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (hit_page) begin
      rd_data = DATA_W'(page_q);
    end else if (hit_stat) begin
      rd_data[STAT_EN_BIT]   = en_q;
      rd_data[STAT_HANG_BIT] = hang_q;
    end
  end

  assign page     = page_q;
  assign irq      = en_q & hang_q;
  assign unit_rst = urst_q;

  AST_URST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    unit_rst |=> !unit_rst); // R8

  AST_HANG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hang_evt |=> rd_data[STAT_HANG_BIT] || !hit_stat || irq == en_q); // R6

  AST_PAGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_page) |=> $stable(page)); // R9
endmodule

// File: rtl/pwb_win_fsm.sv
module pwb_win_fsm
  import pwb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INT_AW = 24,
  parameter int PAGE_W = INT_AW - WIN_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                start_we,
  input  logic [WIN_BITS-1:0] start_off,
  input  logic [DATA_W-1:0]   start_wdata,
  input  logic [PAGE_W-1:0]   page,
  output logic                idle,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  output logic                int_valid,
  output logic                int_we,
  output logic [INT_AW-1:0]   int_addr,
  output logic [DATA_W-1:0]   int_wdata,
  input  logic                int_ready,
  input  logic [DATA_W-1:0]   int_rdata
);
  win_state_e        st_q, st_d;
  logic              load_req, cap_rsp;
  logic [INT_AW-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    load_req = (st_q == WIN_IDLE) & start;
    cap_rsp  = (st_q == WIN_REQ) & int_ready;
    st_d     = st_q;
    case (st_q)
      WIN_IDLE: if (start)     st_d = WIN_REQ;
      WIN_REQ:  if (int_ready) st_d = WIN_DONE;
      WIN_DONE:                st_d = WIN_IDLE;
      default:                 st_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= WIN_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (load_req) begin
      addr_q  <= {page, start_off};
      we_q    <= start_we;
      wdata_q <= start_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_rsp) begin
      rdata_q <= we_q ? '0 : int_rdata;
    end
  end

  assign idle      = (st_q == WIN_IDLE);
  assign done      = (st_q == WIN_DONE);
  assign rdata     = rdata_q;
  assign int_valid = (st_q == WIN_REQ);
  assign int_we    = we_q;
  assign int_addr  = addr_q;
  assign int_wdata = wdata_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && !int_ready) |=>
      (int_valid && $stable(int_addr) && $stable(int_we) && $stable(int_wdata))); // R4

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && int_ready) |=> !int_valid); // R3
endmodule

// File: rtl/paged_window_bridge.sv
module paged_window_bridge
  import pwb_pkg::*;
#(
  parameter int HOST_AW = 12,
  parameter int DATA_W  = 32,
  parameter int INT_AW  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_ready,
  output logic               int_valid,
  output logic               int_we,
  output logic [INT_AW-1:0]  int_addr,
  output logic [DATA_W-1:0]  int_wdata,
  input  logic               int_ready,
  input  logic [DATA_W-1:0]  int_rdata,
  input  logic               fw_hang_evt,
  output logic               irq,
  output logic               unit_rst
);
  localparam int PAGE_W = INT_AW - WIN_BITS;
  localparam int WSEL_W = HOST_AW - WIN_BITS;
  localparam logic [WSEL_W-1:0] WIN_SEL = WSEL_W'(WIN_OFS >> WIN_BITS);

  logic              rst_sn;
  logic              win_hit;
  logic              fsm_idle, fsm_done;
  logic [DATA_W-1:0] fsm_rdata, cfg_rdata;
  logic [PAGE_W-1:0] page;
  logic              cfg_wr;

  pwb_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign win_hit = (host_addr[HOST_AW-1:WIN_BITS] == WIN_SEL);
  assign cfg_wr  = host_sel & host_wr & fsm_idle & ~win_hit;

  pwb_cfg_regs #(
    .HOST_AW (HOST_AW),
    .DATA_W  (DATA_W),
    .PAGE_W  (PAGE_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (cfg_wr),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .hang_evt (fw_hang_evt),
    .page     (page),
    .rd_data  (cfg_rdata),
    .irq      (irq),
    .unit_rst (unit_rst)
  );

  pwb_win_fsm #(
    .DATA_W (DATA_W),
    .INT_AW (INT_AW),
    .PAGE_W (PAGE_W)
  ) u_win (
    .clk         (clk),
    .rst_n       (rst_sn),
    .start       (host_sel & win_hit),
    .start_we    (host_wr),
    .start_off   (host_addr[WIN_BITS-1:0]),
    .start_wdata (host_wdata),
    .page        (page),
    .idle        (fsm_idle),
    .done        (fsm_done),
    .rdata       (fsm_rdata),
    .int_valid   (int_valid),
    .int_we      (int_we),
    .int_addr    (int_addr),
    .int_wdata   (int_wdata),
    .int_ready   (int_ready),
    .int_rdata   (int_rdata)
  );

  assign host_ready = fsm_done | (fsm_idle & host_sel & ~win_hit);
  assign host_rdata = fsm_done ? fsm_rdata : cfg_rdata;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    int_valid |-> !host_ready); // R4

  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_sn)
    (int_valid && int_ready) |=> host_ready); // R5

  AST_WIN_PAGE: assert property (@(posedge clk) disable iff (!rst_sn)
    (int_valid && !$past(int_valid)) |-> int_addr[INT_AW-1:WIN_BITS] == page); // R3
endmodule

// File: tb/paged_window_bridge_test.sv
module paged_window_bridge_test;
  localparam int CLK_P   = 10;
  localparam int HOST_AW = 12;
  localparam int DATA_W  = 32;
  localparam int INT_AW  = 16;
  localparam int PAGE_W  = INT_AW - 9;

  logic               clk;
  logic               rst_n;
  logic               host_sel, host_wr;
  logic [HOST_AW-1:0] host_addr;
  logic [DATA_W-1:0]  host_wdata;
  logic [DATA_W-1:0]  host_rdata;
  logic               host_ready;
  logic               int_valid, int_we;
  logic [INT_AW-1:0]  int_addr;
  logic [DATA_W-1:0]  int_wdata;
  logic               int_ready;
  logic [DATA_W-1:0]  int_rdata;
  logic               fw_hang_evt;
  logic               irq, unit_rst;

  int checks, fails;
  int resp_delay, wait_cnt, hs_cnt;
  logic [INT_AW-1:0] seen_addr, log_addr;
  logic              log_we;
  logic [DATA_W-1:0] log_wdata;
  bit finished;

  paged_window_bridge #(
    .HOST_AW (HOST_AW), .DATA_W (DATA_W), .INT_AW (INT_AW)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .host_sel (host_sel), .host_wr (host_wr), .host_addr (host_addr),
    .host_wdata (host_wdata), .host_rdata (host_rdata), .host_ready (host_ready),
    .int_valid (int_valid), .int_we (int_we), .int_addr (int_addr),
    .int_wdata (int_wdata), .int_ready (int_ready), .int_rdata (int_rdata),
    .fw_hang_evt (fw_hang_evt), .irq (irq), .unit_rst (unit_rst)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] model(input logic [INT_AW-1:0] a);
    return {~a, a ^ 16'h1234};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // internal-port responder
  initial begin
    int_ready = 1'b0;
    int_rdata = '0;
    wait_cnt  = 0;
    hs_cnt    = 0;
    forever begin
      @(negedge clk);
      int_ready = 1'b0;
      if (int_valid) begin
        if (wait_cnt == 0) seen_addr = int_addr;
        else chk("R4 addr held", 32'(int_addr), 32'(seen_addr));
        chk("R4 host stalled", 32'(host_ready), 32'd0);
        if (wait_cnt == resp_delay) begin
          int_ready = 1'b1;
          int_rdata = model(int_addr);
          log_addr  = int_addr;
          log_we    = int_we;
          log_wdata = int_wdata;
          hs_cnt++;
          wait_cnt  = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic access(input logic wr, input logic [HOST_AW-1:0] a,
                        input logic [DATA_W-1:0] wd,
                        output logic [DATA_W-1:0] rd, output int cyc);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = wd;
    cyc = 0;
    forever begin
      #(CLK_P/4);
      if (host_ready) break;
      @(negedge clk);
      cyc++;
    end
    rd = host_rdata;
    @(posedge clk);
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  initial begin
    logic [DATA_W-1:0] rd;
    int cyc, hs0;
    host_sel = 0; host_wr = 0; host_addr = '0; host_wdata = '0;
    fw_hang_evt = 0; resp_delay = 0;
    checks = 0; fails = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 unit_rst", 32'(unit_rst), 0);
    chk("R1 int_valid", 32'(int_valid), 0);
    access(0, 12'h41C, 0, rd, cyc); chk("R1 page", rd, 0);
    chk("R10 latency", 32'(cyc), 0);
    access(0, 12'h428, 0, rd, cyc); chk("R1 status", rd, 0);

    // sweep every page
    for (int p = 0; p < (1 << PAGE_W); p++) begin
      logic [8:0] offs [3];
      offs[0] = 9'h000; offs[1] = 9'h1FF; offs[2] = 9'(p * 37 + 5);
      access(1, 12'h41C, 32'(p) | 32'hABCD_0000, rd, cyc);
      access(0, 12'h41C, 0, rd, cyc);
      chk("R2 page readback", rd, 32'(p));
      for (int k = 0; k < 3; k++) begin
        logic [INT_AW-1:0] ea;
        ea = {PAGE_W'(p), offs[k]};
        resp_delay = (p + k) % 4;
        access(1, {3'b100, offs[k]}, 32'hF00D_0000 ^ 32'(ea), rd, cyc);
        chk("R3 write addr", 32'(log_addr), 32'(ea));
        chk("R3 write we", 32'(log_we), 1);
        chk("R3 write data", log_wdata, 32'hF00D_0000 ^ 32'(ea));
        chk("R5 write latency", 32'(cyc), 32'(2 + resp_delay));
        access(0, {3'b100, offs[k]}, 0, rd, cyc);
        chk("R3 read addr", 32'(log_addr), 32'(ea));
        chk("R3 read we", 32'(log_we), 0);
        chk("R5 read data", rd, model(ea));
        chk("R5 read latency", 32'(cyc), 32'(2 + resp_delay));
      end
    end
    resp_delay = 0;

    // R2 high bits dropped
    access(1, 12'h41C, 32'hFFFF_FF85, rd, cyc);
    access(0, 12'h41C, 0, rd, cyc); chk("R2 masked", rd, 32'h05);

    // R6 hang flag
    @(negedge clk) fw_hang_evt = 1;
    @(negedge clk) fw_hang_evt = 0;
    access(0, 12'h428, 0, rd, cyc); chk("R6 set", rd, 32'h2);
    chk("R7 irq disabled", 32'(irq), 0);
    access(1, 12'h428, 0, rd, cyc);
    access(0, 12'h428, 0, rd, cyc); chk("R6 write0 keeps", rd, 32'h2);
    access(1, 12'h428, 32'h8, rd, cyc);
    access(0, 12'h428, 0, rd, cyc); chk("R7 enable", rd, 32'hA);
    chk("R7 irq on", 32'(irq), 1);
    access(1, 12'h428, 32'hA, rd, cyc);
    access(0, 12'h428, 0, rd, cyc); chk("R6 w1c", rd, 32'h8);
    chk("R7 irq off", 32'(irq), 0);
    // simultaneous event and clearing write
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = 12'h428; host_wdata = 32'hA;
    fw_hang_evt = 1;
    @(negedge clk);
    host_sel = 0; host_wr = 0; fw_hang_evt = 0;
    access(0, 12'h428, 0, rd, cyc); chk("R6 set wins", rd, 32'hA);
    chk("R7 irq both", 32'(irq), 1);
    access(1, 12'h428, 32'h2, rd, cyc);
    access(0, 12'h428, 0, rd, cyc); chk("R7 disable", rd, 32'h0);

    // R8 unit reset pulse
    access(1, 12'h42C, 32'h1, rd, cyc);
    chk("R8 pulse", 32'(unit_rst), 1);
    @(negedge clk); chk("R8 single", 32'(unit_rst), 0);
    access(1, 12'h42C, 32'hFFFF_FFFE, rd, cyc);
    chk("R8 no pulse", 32'(unit_rst), 0);
    access(0, 12'h42C, 0, rd, cyc); chk("R8 reads zero", rd, 0);

    // R9 unmapped offsets
    access(1, 12'h41C, 32'h33, rd, cyc);
    hs0 = hs_cnt;
    begin
      logic [HOST_AW-1:0] um [6];
      um[0] = 12'h000; um[1] = 12'h418; um[2] = 12'h420;
      um[3] = 12'h7FC; um[4] = 12'hA00; um[5] = 12'hFFC;
      for (int i = 0; i < 6; i++) begin
        access(1, um[i], 32'hFFFF_FFFF, rd, cyc);
        chk("R10 unmapped ready", 32'(cyc), 0);
        access(0, um[i], 0, rd, cyc);
        chk("R9 reads zero", rd, 0);
      end
    end
    chk("R9 no request", 32'(hs_cnt), 32'(hs0));
    access(0, 12'h41C, 0, rd, cyc); chk("R9 page kept", rd, 32'h33);
    access(0, 12'h428, 0, rd, cyc); chk("R9 status kept", rd, 0);
    chk("R9 no unit_rst", 32'(unit_rst), 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule